// File: doc/BRIEF.md
# DRAM Warm-Up and Refresh Sequencer

This block sits on the controller side of an asynchronous fast-page-mode DRAM. It owns the RAS and CAS strobes and the row address whenever the memory is not being used for a data access. After reset it holds the strobes inactive for a power-up pause. It then runs a fixed number of warm-up refresh cycles before it reports the memory as usable. In normal operation it schedules refresh in one of two modes. The distributed mode issues one CAS-before-RAS cycle per interval. The burst mode issues a back-to-back run of RAS-only cycles that covers every row once per period.

A host access port shares the memory through a level request and a grant. The grant is given only when no refresh is pending or running. A refresh that falls due during a host cycle is issued as soon as the host drops its request, before any new grant. A self-refresh request puts the memory into self refresh, after a catch-up refresh that matches the active mode. The memory is entered with CAS falling before RAS and both strobes held low. When the request is released, the block applies a normal or an extended precharge, depending on how long RAS stayed low, and then runs the exit catch-up refresh.

All times are given in nanoseconds and turned into clock cycles from a clock-period parameter. The mode inputs are configuration levels and are expected to change only while reset is held.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset release, RAS and CAS stay high, `ready_o` stays low and no grant is given for at least PAUSE cycles.
- R2: After the pause, exactly WARM_N refresh cycles are issued before `ready_o` rises. They are CAS-before-RAS cycles in distributed mode and RAS-only cycles in burst mode.
- R3: In a CAS-before-RAS cycle, CAS falls at least T_CSR cycles before RAS. RAS stays low for exactly T_RAS cycles. `row_oe_o` stays low.
- R4: In a RAS-only cycle, CAS stays high and `row_oe_o` is high. `row_addr_o` carries the internal row counter, which advances by one after each such cycle. It wraps to 0 after row ROWS-1, or after row ROWS/2-1 when `half_rows_i` is 1.
- R5: When `burst_mode_i` is 0 and the port is idle, successive refresh cycles start exactly INTERVAL cycles apart.
- R6: When `burst_mode_i` is 1, the first burst starts about one burst period after `ready_o` rises. The period is BURST cycles, halved when `half_rows_i` is 1. Each burst is ROWS back-to-back RAS-only cycles, or ROWS/2 cycles when `half_rows_i` is 1.
- R7: `host_gnt_o` is given only while the strobe engine is idle and no refresh is pending. It holds RAS and CAS high, and it lasts until `host_req_i` drops. A refresh that fell due meanwhile is issued before the next grant.
- R8: When `sr_req_i` rises, `ready_o` falls. One refresh (distributed mode) or a full burst (burst mode) is issued. The block then enters self refresh with CAS before RAS and holds RAS low while `sr_req_i` stays high.
- R9: On self-refresh exit, RAS stays high for at least T_RP cycles. If RAS was low for more than LONG_SR cycles, it stays high for at least T_RPS cycles. The block then issues one refresh (distributed mode) or a full burst (burst mode) before `ready_o` rises again.
- R10: In distributed mode, `interval_err_o` rises when more than MAX_GAP cycles pass between refresh completions while the port is usable. It stays high until reset. It stays low while refresh keeps its schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_mode_i | input | 1 | 0: distributed CAS-before-RAS, 1: burst RAS-only |
| half_rows_i | input | 1 | 1: half row count and half burst period |
| sr_req_i | input | 1 | Level request to enter and stay in self refresh |
| host_req_i | input | 1 | Level request from the host access port |
| host_gnt_o | output | 1 | Host owns the memory |
| ready_o | output | 1 | Memory is usable for host access |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| row_addr_o | output | $clog2(ROWS) | Refresh row for RAS-only cycles |
| row_oe_o | output | 1 | Row address is valid and must be driven |
| interval_err_o | output | 1 | Sticky refresh-gap violation flag |

## Verification
The hardest state to reach from the ports is an exit from self refresh after RAS has been low past the long threshold. It is only observable as the width of the RAS-high gap before the exit refresh. The bench enters self refresh from a known offset after a periodic refresh, so no scheduled cycle can interfere. It holds the request once well beyond and once well under the threshold. It then compares the two measured gaps against the normal and the extended precharge lengths. The row wrap and the interval-error flag are reached the same way: bursts that run across the last row, and a host request held past the allowed gap.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACT,
      PH_HOLD,
      PH_PRE
   } strobe_ph_t;

   typedef enum logic [2:0] {
      ST_PAUSE,
      ST_WARM,
      ST_IDLE,
      ST_HOST,
      ST_REF,
      ST_SR_PRE,
      ST_SR_IN,
      ST_SR_POST
   } seq_st_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int ns_to_cyc(input longint ns, input longint clk_ps);
      return int'((ns * 64'd1000 + clk_ps - 64'd1) / clk_ps);
   endfunction

endpackage

// File: rtl/rfsh_strobe_eng.sv
module rfsh_strobe_eng
   import dram_rfsh_pkg::*;
#(
   parameter int TCSR_C = 2,
   parameter int TRAS_C = 5,
   parameter int TRP_C  = 3,
   parameter int TRPS_C = 10,
   parameter int LONG_C = 50
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cbr_i,
   input  logic sr_i,
   input  logic hold_i,
   output logic busy_o,
   output logic done_o,
   output logic row_adv_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic addr_en_o
);
   localparam int MAXP = imax(imax(TCSR_C, TRAS_C), imax(TRP_C, TRPS_C));
   localparam int CW   = $clog2(MAXP + 1);
   localparam int HW   = $clog2(LONG_C + 2);

   strobe_ph_t     ph;
   logic [CW-1:0]  cnt;
   logic [HW-1:0]  hcnt;
   logic           cbr_q;
   logic           sr_q;
   logic           long_low;

   assign long_low = (hcnt > HW'(LONG_C));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         hcnt  <= '0;
         cbr_q <= 1'b0;
         sr_q  <= 1'b0;
      end else begin
         case (ph)
            PH_IDLE: if (start_i) begin
               ph    <= PH_SETUP;
               cnt   <= CW'(TCSR_C - 1);
               cbr_q <= cbr_i | sr_i;
               sr_q  <= sr_i;
               hcnt  <= '0;
            end
            PH_SETUP: if (cnt == '0) begin
               ph  <= sr_q ? PH_HOLD : PH_ACT;
               cnt <= CW'(TRAS_C - 1);
            end else cnt <= cnt - 1'b1;
            PH_ACT: if (cnt == '0) begin
               ph  <= PH_PRE;
               cnt <= CW'(TRP_C - 1);
            end else cnt <= cnt - 1'b1;
            PH_HOLD: begin
               if (hcnt != HW'(LONG_C + 1)) hcnt <= hcnt + 1'b1;
               if (!hold_i && hcnt >= HW'(TRAS_C)) begin
                  ph  <= PH_PRE;
                  cnt <= long_low ? CW'(TRPS_C - 1) : CW'(TRP_C - 1);
               end
            end
            PH_PRE: if (cnt == '0) ph <= PH_IDLE;
                    else cnt <= cnt - 1'b1;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy_o    = (ph != PH_IDLE);
   assign done_o    = (ph == PH_PRE) && (cnt == '0);
   assign row_adv_o = done_o && !cbr_q;
   assign ras_n_o   = !((ph == PH_ACT) || (ph == PH_HOLD));
   assign cas_n_o   = !(cbr_q && ((ph == PH_SETUP) || (ph == PH_ACT) || (ph == PH_HOLD)));
   assign addr_en_o = !cbr_q && ((ph == PH_SETUP) || (ph == PH_ACT));

   // R3: column strobe already low in the cycle before RAS falls
   p_cas_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cbr_q && $fell(ras_n_o)) |-> $past(!cas_n_o));

   // R4: RAS-only cycles never pull CAS low
   p_cas_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cbr_q && busy_o) |-> cas_n_o);

   // R9: a long self-refresh low period selects the extended precharge
   p_long_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HOLD && !hold_i && hcnt >= HW'(TRAS_C) && long_low)
      |=> (ph == PH_PRE && cnt == CW'(TRPS_C - 1)));
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
   parameter int ROWS    = 16,
   parameter bit HALF_EN = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv_i,
   input  logic                    half_i,
   output logic [$clog2(ROWS)-1:0] row_o
);
   localparam int RW = $clog2(ROWS);

   logic [RW-1:0] last_row;

   generate
      if (HALF_EN) begin : g_half
         assign last_row = half_i ? RW'(ROWS / 2 - 1) : RW'(ROWS - 1);
      end else begin : g_full
         logic unused_half;
         assign unused_half = half_i;
         assign last_row    = RW'(ROWS - 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_o <= '0;
      else if (adv_i)  row_o <= (row_o == last_row) ? '0 : row_o + 1'b1;
   end

   // R4: the counter returns to row 0 after the last row
   p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && row_o == last_row) |=> (row_o == '0));
endmodule

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         load_i,
   input  logic [W-1:0] lim_i,
   output logic         tick_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load_i)      cnt <= lim_i;
      else if (run_i) begin
         if (cnt == '0)     cnt <= lim_i;
         else               cnt <= cnt - 1'b1;
      end
   end

   assign tick_o = run_i && !load_i && (cnt == '0);
endmodule

// File: rtl/rfsh_gap_mon.sv
module rfsh_gap_mon #(
   parameter int GAP_C = 150
)(
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic clr_i,
   output logic err_o
);
   localparam int GW = $clog2(GAP_C + 1);

   logic [GW-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap   <= '0;
         err_o <= 1'b0;
      end else begin
         if (!en_i || clr_i)           gap <= '0;
         else if (gap != GW'(GAP_C))   gap <= gap + 1'b1;
         if (en_i && gap == GW'(GAP_C)) err_o <= 1'b1;
      end
   end

   // R10: once raised the flag holds until reset
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_rfsh_pkg::*;
#(
   parameter int CLK_PS   = 8000,
   parameter int PAUSE_NS = 200000,
   parameter int INT_NS   = 15600,
   parameter int BURST_NS = 64000000,
   parameter int TCSR_NS  = 10,
   parameter int TRAS_NS  = 60,
   parameter int TRP_NS   = 40,
   parameter int TRPS_NS  = 110,
   parameter int LONG_NS  = 100000,
   parameter int GAP_NS   = 16000,
   parameter int ROWS     = 4096,
   parameter int WARM_N   = 8,
   parameter bit HALF_EN  = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    burst_mode_i,
   input  logic                    half_rows_i,
   input  logic                    sr_req_i,
   input  logic                    host_req_i,
   output logic                    host_gnt_o,
   output logic                    ready_o,
   output logic                    ras_n_o,
   output logic                    cas_n_o,
   output logic [$clog2(ROWS)-1:0] row_addr_o,
   output logic                    row_oe_o,
   output logic                    interval_err_o
);
   localparam int PAUSE_C = ns_to_cyc(PAUSE_NS, CLK_PS);
   localparam int INT_C   = ns_to_cyc(INT_NS, CLK_PS);
   localparam int BURST_C = ns_to_cyc(BURST_NS, CLK_PS);
   localparam int TCSR_C  = ns_to_cyc(TCSR_NS, CLK_PS);
   localparam int TRAS_C  = ns_to_cyc(TRAS_NS, CLK_PS);
   localparam int TRP_C   = ns_to_cyc(TRP_NS, CLK_PS);
   localparam int TRPS_C  = ns_to_cyc(TRPS_NS, CLK_PS);
   localparam int LONG_C  = ns_to_cyc(LONG_NS, CLK_PS);
   localparam int GAP_C   = ns_to_cyc(GAP_NS, CLK_PS);
   localparam int PW      = $clog2(PAUSE_C + 1);
   localparam int TW      = $clog2(imax(BURST_C, INT_C) + 1);
   localparam int NW      = $clog2(imax(ROWS, WARM_N) + 1);

   generate
      if (ROWS < 4 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("ROWS must be a power of two of at least 4");
      end
      if (TCSR_C < 1 || TRAS_C < 1 || TRP_C < 1 || TRPS_C < TRP_C) begin : g_bad_strobe
         $error("strobe timings must be at least one cycle, with TRPS >= TRP");
      end
      if (LONG_C < TRAS_C) begin : g_bad_long
         $error("long self-refresh threshold must cover T_RAS");
      end
      if (GAP_C <= INT_C || BURST_C < 4 || WARM_N < 1) begin : g_bad_sched
         $error("gap limit must exceed the interval; burst period and warm count too small");
      end
   endgenerate

   seq_st_t        st;
   logic [PW-1:0]  pcnt;
   logic [NW-1:0]  ref_left;
   logic [NW-1:0]  nref;
   logic [TW-1:0]  per_lim;
   logic           pend;
   logic           half_eff;
   logic           eng_busy, eng_idle, eng_done, row_adv, addr_en;
   logic           ref_state, ref_start, sr_start, tmr_run, tmr_load, tick;

   assign half_eff  = HALF_EN ? half_rows_i : 1'b0;
   assign eng_idle  = !eng_busy;
   assign nref      = !burst_mode_i ? NW'(1) : (half_eff ? NW'(ROWS / 2) : NW'(ROWS));
   assign per_lim   = !burst_mode_i ? TW'(INT_C - 1)
                    : (half_eff ? TW'(BURST_C / 2 - 1) : TW'(BURST_C - 1));

   assign ref_state = (st == ST_WARM) || (st == ST_REF) || (st == ST_SR_PRE) || (st == ST_SR_POST);
   assign ref_start = ref_state && eng_idle && (ref_left != '0);
   assign sr_start  = (st == ST_SR_PRE) && eng_idle && (ref_left == '0);
   assign tmr_run   = (st == ST_IDLE) || (st == ST_HOST) || (st == ST_REF);
   assign tmr_load  = ((st == ST_WARM) || (st == ST_SR_POST)) && eng_idle && (ref_left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_PAUSE;
         pcnt     <= '0;
         ref_left <= '0;
         pend     <= 1'b0;
      end else begin
         if (tick) pend <= 1'b1;
         case (st)
            ST_PAUSE: begin
               if (pcnt == PW'(PAUSE_C - 1)) begin
                  st       <= ST_WARM;
                  ref_left <= NW'(WARM_N);
               end else pcnt <= pcnt + 1'b1;
            end
            ST_WARM, ST_REF, ST_SR_POST: begin
               if (ref_start) ref_left <= ref_left - 1'b1;
               else if (ref_left == '0 && eng_idle) begin
                  st <= ST_IDLE;
                  if (st != ST_REF) pend <= 1'b0;
               end
            end
            ST_SR_PRE: begin
               if (ref_start)     ref_left <= ref_left - 1'b1;
               else if (sr_start) st <= ST_SR_IN;
            end
            ST_SR_IN: begin
               if (eng_done) begin
                  st       <= ST_SR_POST;
                  ref_left <= nref;
               end
            end
            ST_IDLE: begin
               if (pend) begin
                  st       <= ST_REF;
                  ref_left <= nref;
                  pend     <= 1'b0;
               end else if (sr_req_i) begin
                  st       <= ST_SR_PRE;
                  ref_left <= nref;
               end else if (host_req_i) st <= ST_HOST;
            end
            ST_HOST: if (!host_req_i) st <= ST_IDLE;
            default: st <= ST_PAUSE;
         endcase
      end
   end

   rfsh_strobe_eng #(
      .TCSR_C (TCSR_C),
      .TRAS_C (TRAS_C),
      .TRP_C  (TRP_C),
      .TRPS_C (TRPS_C),
      .LONG_C (LONG_C)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (ref_start | sr_start),
      .cbr_i     (!burst_mode_i),
      .sr_i      (sr_start),
      .hold_i    (sr_req_i),
      .busy_o    (eng_busy),
      .done_o    (eng_done),
      .row_adv_o (row_adv),
      .ras_n_o   (ras_n_o),
      .cas_n_o   (cas_n_o),
      .addr_en_o (addr_en)
   );

   rfsh_row_ctr #(
      .ROWS    (ROWS),
      .HALF_EN (HALF_EN)
   ) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (row_adv),
      .half_i (half_eff),
      .row_o  (row_addr_o)
   );

   rfsh_tick #(
      .W (TW)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (tmr_run),
      .load_i (tmr_load),
      .lim_i  (per_lim),
      .tick_o (tick)
   );

   rfsh_gap_mon #(
      .GAP_C (GAP_C)
   ) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (ready_o && !burst_mode_i),
      .clr_i (eng_done),
      .err_o (interval_err_o)
   );

   assign row_oe_o   = addr_en;
   assign host_gnt_o = (st == ST_HOST);
   assign ready_o    = tmr_run;

   // R1: strobes quiet and no grant while the power-up pause runs
   p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PAUSE) |-> (ras_n_o && cas_n_o && !host_gnt_o && !ready_o));

   // R7: a granted host never overlaps a running strobe sequence
   p_gnt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_gnt_o |-> (!eng_busy && ras_n_o && cas_n_o));

   // R8: while the memory sits in self refresh the port is not usable
   p_sr_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n_o && !cas_n_o && sr_req_i && st == ST_SR_IN) |-> (!ready_o && !host_gnt_o));
endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
   localparam int P_C     = 100;
   localparam int INT_C   = 100;
   localparam int BURST_C = 500;
   localparam int TCSR_C  = 2;
   localparam int TRAS_C  = 5;
   localparam int TRP_C   = 3;
   localparam int TRPS_C  = 10;
   localparam int ROWS    = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       burst_mode = 1'b0;
   logic       half_rows = 1'b0;
   logic       sr_req = 1'b0;
   logic       host_req = 1'b0;
   logic       host_gnt, ready, ras_n, cas_n, row_oe, ierr;
   logic [3:0] row;

   int nchk = 0;
   int nfail = 0;

   dram_refresh_seq #(
      .CLK_PS   (8000),
      .PAUSE_NS (800),
      .INT_NS   (800),
      .BURST_NS (4000),
      .TCSR_NS  (16),
      .TRAS_NS  (40),
      .TRP_NS   (24),
      .TRPS_NS  (80),
      .LONG_NS  (400),
      .GAP_NS   (1200),
      .ROWS     (ROWS),
      .WARM_N   (8),
      .HALF_EN  (1'b1)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .burst_mode_i   (burst_mode),
      .half_rows_i    (half_rows),
      .sr_req_i       (sr_req),
      .host_req_i     (host_req),
      .host_gnt_o     (host_gnt),
      .ready_o        (ready),
      .ras_n_o        (ras_n),
      .cas_n_o        (cas_n),
      .row_addr_o     (row),
      .row_oe_o       (row_oe),
      .interval_err_o (ierr)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // strobe monitor, sampled on the falling clock edge
   int cyc = 0, nfall = 0, ncaslow = 0;
   int fall_cyc = 0, rise_cyc = 0, cas_fall_cyc = 0;
   int last_low = 0, last_high = 0, last_lead = 0;
   bit last_cbr = 1'b0;
   int exp_row = 0, row_lim = ROWS;
   bit prev_ras = 1'b1, prev_cas = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         exp_row = 0; nfall = 0; ncaslow = 0;
         prev_ras = 1'b1; prev_cas = 1'b1;
      end else begin
         if (prev_cas && !cas_n) cas_fall_cyc = cyc;
         if (!cas_n) ncaslow++;
         if (prev_ras && !ras_n) begin
            nfall++;
            last_high = cyc - rise_cyc;
            fall_cyc  = cyc;
            last_cbr  = !cas_n;
            last_lead = cyc - cas_fall_cyc;
            if (row_oe) begin
               chk(row == 4'(exp_row), "R4", "row at RAS fall", int'(row), exp_row);
               exp_row = (exp_row + 1) % row_lim;
            end
         end
         if (!prev_ras && ras_n) begin
            rise_cyc = cyc;
            last_low = cyc - fall_cyc;
         end
         prev_ras = ras_n;
         prev_cas = cas_n;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_fall();
      int base = nfall;
      while (nfall == base) step();
   endtask

   task automatic wait_ready();
      while (!ready) step();
   endtask

   task automatic do_reset(input bit burst, input bit half);
      step();
      rst_n = 1'b0; burst_mode = burst; half_rows = half;
      sr_req = 1'b0; host_req = 1'b0;
      row_lim = half ? ROWS / 2 : ROWS;
      repeat (3) step();
      chk(ready == 1'b0 && ras_n && cas_n && !host_gnt, "R1", "state in reset",
          {ready, ras_n, cas_n, host_gnt}, 4'b0110);
      rst_n = 1'b1;
   endtask

   // R1, R2, R3, R7: pause, warm-up and first grant in distributed mode
   task automatic t_powerup_dist();
      int n = 0;
      bit gnt_seen = 1'b0;
      do_reset(1'b0, 1'b0);
      host_req = 1'b1;
      while (ras_n && cas_n) begin
         step(); n++;
         if (host_gnt || ready) gnt_seen = 1'b1;
      end
      chk(n >= P_C && n <= P_C + 3, "R1", "cycles before first strobe", n, P_C);
      while (!ready) begin
         step();
         if (host_gnt) gnt_seen = 1'b1;
      end
      chk(!gnt_seen, "R1", "grant or ready during pause/warm-up", gnt_seen, 0);
      chk(nfall == 8, "R2", "warm-up refresh count", nfall, 8);
      chk(last_cbr, "R2", "warm-up cycle is CAS-before-RAS", last_cbr, 1);
      chk(last_low == TRAS_C, "R3", "RAS low width", last_low, TRAS_C);
      chk(last_lead >= TCSR_C, "R3", "CAS lead before RAS", last_lead, TCSR_C);
      chk(last_high >= TRP_C, "R3", "RAS precharge", last_high, TRP_C);
      step(); step();
      chk(host_gnt, "R7", "grant after ready", host_gnt, 1);
      host_req = 1'b0;
      step();
   endtask

   // R5: periodic spacing
   task automatic t_interval();
      int f1;
      wait_fall();
      f1 = fall_cyc;
      wait_fall();
      chk(fall_cyc - f1 == INT_C, "R5", "refresh spacing", fall_cyc - f1, INT_C);
      chk(!row_oe && last_cbr, "R3", "distributed cycle is CBR without address",
          {row_oe, last_cbr}, 2'b01);
   endtask

   // R7: host arbitration around a due refresh
   task automatic t_host();
      int base, bad = 0, t0;
      wait_fall();
      repeat (20) step();
      host_req = 1'b1;
      step(); step();
      chk(host_gnt, "R7", "grant with nothing pending", host_gnt, 1);
      base = nfall;
      repeat (110) begin
         step();
         if (!host_gnt || !ras_n || !cas_n) bad++;
      end
      chk(bad == 0 && nfall == base, "R7", "strobes quiet during grant", bad, 0);
      host_req = 1'b0;
      step();
      host_req = 1'b1;
      t0 = cyc;
      while (!host_gnt) step();
      chk(nfall == base + 1, "R7", "due refresh issued before regrant", nfall, base + 1);
      chk(cyc - t0 > TCSR_C + TRAS_C + TRP_C, "R7", "regrant delayed by refresh",
          cyc - t0, TCSR_C + TRAS_C + TRP_C + 1);
      host_req = 1'b0;
      step();
   endtask

   // R8, R9: self refresh entry and exit, distributed mode
   task automatic t_sr_dist(input int hold, input bit long_exp);
      int base, bad = 0, rdy_seen = 0;
      wait_fall();
      repeat (20) step();
      base = nfall;
      sr_req = 1'b1;
      while (nfall < base + 2) begin
         step();
         if (ready) rdy_seen++;
      end
      chk(rdy_seen <= 1 && !ready, "R8", "ready low on entry", ready, 0);
      chk(last_cbr, "R8", "self refresh entered CAS first", last_cbr, 1);
      repeat (hold) begin
         step();
         if (ras_n || cas_n || ready) bad++;
      end
      chk(bad == 0, "R8", "strobes held low in self refresh", bad, 0);
      sr_req = 1'b0;
      while (nfall < base + 3) begin
         step();
         if (ready) bad++;
      end
      chk(bad == 0, "R9", "ready low until exit refresh", bad, 0);
      if (long_exp)
         chk(last_high >= TRPS_C, "R9", "long precharge after long low", last_high, TRPS_C);
      else
         chk(last_high >= TRP_C && last_high < TRPS_C, "R9", "normal precharge", last_high, TRP_C);
      wait_ready();
      chk(nfall == base + 3, "R9", "one exit refresh then ready", nfall, base + 3);
   endtask

   // R10: sticky interval error
   task automatic t_gap_err();
      chk(ierr == 1'b0, "R10", "no error on schedule", ierr, 0);
      wait_fall();
      repeat (20) step();
      host_req = 1'b1;
      repeat (300) step();
      chk(ierr == 1'b1, "R10", "error after long host hold", ierr, 1);
      host_req = 1'b0;
      repeat (150) step();
      chk(ierr == 1'b1, "R10", "error stays set", ierr, 1);
   endtask

   // R2, R4, R6, R8, R9: burst mode
   task automatic t_burst(input bit half);
      int t_rdy, base, per, nb;
      per = half ? BURST_C / 2 : BURST_C;
      nb  = half ? ROWS / 2 : ROWS;
      do_reset(1'b1, half);
      wait_ready();
      t_rdy = cyc;
      chk(nfall == 8, "R2", "burst-mode warm-up count", nfall, 8);
      chk(ncaslow == 0, "R4", "RAS-only keeps CAS high", ncaslow, 0);
      wait_fall();
      chk(fall_cyc - t_rdy >= per && fall_cyc - t_rdy <= per + 8, "R6",
          "delay to first burst", fall_cyc - t_rdy, per);
      base = nfall - 1;
      repeat (per / 2) step();
      chk(nfall - base == nb, "R6", "burst length", nfall - base, nb);
      chk(ncaslow == 0, "R4", "CAS high through burst", ncaslow, 0);
      chk(int'(row) == (8 + nb) % (half ? 8 : 16), "R4", "row after wrap",
          int'(row), (8 + nb) % (half ? 8 : 16));
      if (!half) begin
         base = nfall;
         sr_req = 1'b1;
         while (nfall < base + nb + 1) step();
         chk(!ready && last_cbr, "R8", "burst then CBR self-refresh entry",
             {ready, last_cbr}, 2'b01);
         repeat (10) step();
         sr_req = 1'b0;
         wait_ready();
         chk(nfall == base + 2 * nb + 1, "R9", "exit burst before ready",
             nfall, base + 2 * nb + 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      t_powerup_dist();
      t_interval();
      t_host();
      t_sr_dist(10, 1'b0);
      t_sr_dist(80, 1'b1);
      t_interval();
      t_gap_err();
      t_burst(1'b0);
      t_burst(1'b1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule